// File: doc/BRIEF.md
# Configurable GPIO Port with Alternate-Function Mux

This block controls eight general-purpose pins through a small byte-wide register bus. Each pin has a direction bit, two style bits and two function-select bits. In output direction the style bits pick one of four drive styles: off, high-only drive, low-only drive or full push-pull. In input direction they pick a floating, pulled-down or pulled-up input. The block does not model pads. It drives abstract pad controls (output enable, output level, pull-up enable, pull-down enable) and takes one sampled level per pad.

Any pin can be handed to one of three alternate peripheral signals. The chosen peripheral then supplies the level and the drive request in place of the data register. The pin's direction and style settings still decide whether and how the pad is driven. Pad levels pass through a two-flop synchroniser. The synchronised levels feed the data-register readback for input pins and are also forwarded, one line per pin, to an external-interrupt path that sits outside this block.

Register writes take effect at the clock edge. Reads are combinational from the current address.

Top module: `gpio_mux_port`

## Requirements
- R1: While reset is held and right after it, every pin is in output direction with style 00 (direction register reads 0xFF and all other registers read 0x00), and no pad is driven or pulled.
- R2: A write with bus_we high at address 0 (data), 1 (direction, 1 = output), 2 (style bit 0), 3 (style bit 1), 4 (select bit 0) or 5 (select bit 1) updates that register at the clock edge. Without a write, registers hold. Reading addresses 1 to 5 returns the register, reading 6 or 7 returns 0, and writes to 6 or 7 change nothing.
- R3: An output pin with style {bit1,bit0} = 00 never drives its pad.
- R4: An output pin with style 01 drives its pad only when its source level is 1 and the source requests drive, and it then drives high.
- R5: An output pin with style 10 drives its pad only when its source level is 0 and the source requests drive, and it then drives low.
- R6: An output pin with style 11 drives its pad whenever the source requests drive, with the source level.
- R7: An input pin never drives. Style 01 enables the pull-down, style 10 enables the pull-up, and styles 00 and 11 enable no pull.
- R8: Reading address 0 returns the data-register bit for output pins and the synchronised pad level for input pins. A pad change is visible two clock edges after it is sampled.
- R9: ext_irq carries the synchronised pad level of every pin, whatever its direction or function, with the same two-edge latency.
- R10: Select code {bit1,bit0} = 00 uses the data register as source with drive always requested. Codes 01, 10 and 11 use alt2, alt3 and alt4 respectively, taking both level and drive request from that peripheral.
- R11: pad_out is 0 on every pin whose pad_oe is 0.
- R12: Pull-up and pull-down are never both enabled on a pin, and neither is enabled on an output pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| alt2_val | input | 8 | Secondary function output levels |
| alt2_en | input | 8 | Secondary function drive requests |
| alt3_val | input | 8 | Tertiary function output levels |
| alt3_en | input | 8 | Tertiary function drive requests |
| alt4_val | input | 8 | Quartic function output levels |
| alt4_en | input | 8 | Quartic function drive requests |
| pad_in | input | 8 | Sampled pad levels |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output levels |
| pad_pu | output | 8 | Pull-up enables |
| pad_pd | output | 8 | Pull-down enables |
| ext_irq | output | 8 | Synchronised levels to the interrupt path |

## Verification
The latency property for ext_irq assumes that pad_in is sampled cleanly at each rising edge. The stimulus therefore changes pad_in, the alternate-function inputs and the bus only at falling edges. It also assumes the default two-stage synchroniser, and the check is generated only for that depth. The register-update properties assume bus_addr and bus_wdata are stable around the edge, which the falling-edge driving guarantees. Random register writes drive every pin through all directions, styles and select codes while the peripheral inputs toggle freely.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        ADDR_DATA  = 3'd0,
        ADDR_DIR   = 3'd1,
        ADDR_STY0  = 3'd2,
        ADDR_STY1  = 3'd3,
        ADDR_FSEL0 = 3'd4,
        ADDR_FSEL1 = 3'd5
    } reg_addr_e;

    // Style code {bit1,bit0}
    typedef enum logic [1:0] {
        STY_OFF  = 2'b00,
        STY_LOW  = 2'b01,   // high-only drive / pull-down
        STY_HIGH = 2'b10,   // low-only drive / pull-up
        STY_BOTH = 2'b11    // push-pull / floating input
    } style_e;

    typedef enum logic [1:0] {
        FN_PORT = 2'b00,
        FN_ALT2 = 2'b01,
        FN_ALT3 = 2'b10,
        FN_ALT4 = 2'b11
    } fsel_e;
endpackage

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [N-1:0]      wdata,
    output logic [N-1:0]      data_q,
    output logic [N-1:0]      dir_q,
    output logic [N-1:0]      sty0_q,
    output logic [N-1:0]      sty1_q,
    output logic [N-1:0]      fsel0_q,
    output logic [N-1:0]      fsel1_q
);
    typedef struct packed {
        logic [N-1:0] data;
        logic [N-1:0] dir;
        logic [N-1:0] sty0;
        logic [N-1:0] sty1;
        logic [N-1:0] fsel0;
        logic [N-1:0] fsel1;
    } regs_t;

    localparam regs_t REGS_RST = '{data: '0, dir: '1, sty0: '0, sty1: '0,
                                   fsel0: '0, fsel1: '0};

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            case (addr)
                ADDR_DATA:  regs_d.data  = wdata;
                ADDR_DIR:   regs_d.dir   = wdata;
                ADDR_STY0:  regs_d.sty0  = wdata;
                ADDR_STY1:  regs_d.sty1  = wdata;
                ADDR_FSEL0: regs_d.fsel0 = wdata;
                ADDR_FSEL1: regs_d.fsel1 = wdata;
                default:    regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    assign data_q  = regs_q.data;
    assign dir_q   = regs_q.dir;
    assign sty0_q  = regs_q.sty0;
    assign sty1_q  = regs_q.sty1;
    assign fsel0_q = regs_q.fsel0;
    assign fsel1_q = regs_q.fsel1;
endmodule

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int N      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pad_in,
    output logic [N-1:0] level
);
    logic [STAGES-1:0][N-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = pad_in;
        for (int k = 1; k < STAGES; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign level = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_ctl.sv
`timescale 1ns/1ps
module gpio_pin_ctl
    import gpio_port_pkg::*;
(
    input  logic       dir_out,
    input  logic [1:0] sty,
    input  logic [1:0] fsel,
    input  logic       port_val,
    input  logic [2:0] alt_val,
    input  logic [2:0] alt_en,
    output logic       oe,
    output logic       out,
    output logic       pu,
    output logic       pd
);
    logic src_val;
    logic src_en;

    always_comb begin
        case (fsel)
            FN_ALT2: begin src_val = alt_val[0]; src_en = alt_en[0]; end
            FN_ALT3: begin src_val = alt_val[1]; src_en = alt_en[1]; end
            FN_ALT4: begin src_val = alt_val[2]; src_en = alt_en[2]; end
            default: begin src_val = port_val;   src_en = 1'b1;      end
        endcase
    end

    always_comb begin
        oe = 1'b0;
        pu = 1'b0;
        pd = 1'b0;
        if (dir_out) begin
            case (sty)
                STY_LOW:  oe = src_en & src_val;
                STY_HIGH: oe = src_en & ~src_val;
                STY_BOTH: oe = src_en;
                default:  oe = 1'b0;
            endcase
        end else begin
            pd = (sty == STY_LOW);
            pu = (sty == STY_HIGH);
        end
        out = oe & src_val;
    end
endmodule

// File: rtl/gpio_mux_port.sv
`timescale 1ns/1ps
module gpio_mux_port
    import gpio_port_pkg::*;
#(
    parameter int N           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    input  logic [N-1:0]      alt2_val,
    input  logic [N-1:0]      alt2_en,
    input  logic [N-1:0]      alt3_val,
    input  logic [N-1:0]      alt3_en,
    input  logic [N-1:0]      alt4_val,
    input  logic [N-1:0]      alt4_en,
    input  logic [N-1:0]      pad_in,
    output logic [N-1:0]      pad_oe,
    output logic [N-1:0]      pad_out,
    output logic [N-1:0]      pad_pu,
    output logic [N-1:0]      pad_pd,
    output logic [N-1:0]      ext_irq
);
    logic [N-1:0] data_q, dir_q, sty0_q, sty1_q, fsel0_q, fsel1_q;
    logic [N-1:0] sync_lvl;

    gpio_regs #(.N(N)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .data_q  (data_q),
        .dir_q   (dir_q),
        .sty0_q  (sty0_q),
        .sty1_q  (sty1_q),
        .fsel0_q (fsel0_q),
        .fsel1_q (fsel1_q)
    );

    gpio_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .level  (sync_lvl)
    );

    for (genvar i = 0; i < N; i++) begin : g_pin
        gpio_pin_ctl u_pin (
            .dir_out  (dir_q[i]),
            .sty      ({sty1_q[i], sty0_q[i]}),
            .fsel     ({fsel1_q[i], fsel0_q[i]}),
            .port_val (data_q[i]),
            .alt_val  ({alt4_val[i], alt3_val[i], alt2_val[i]}),
            .alt_en   ({alt4_en[i], alt3_en[i], alt2_en[i]}),
            .oe       (pad_oe[i]),
            .out      (pad_out[i]),
            .pu       (pad_pu[i]),
            .pd       (pad_pd[i])
        );
    end

    always_comb begin
        case (bus_addr)
            ADDR_DATA:  bus_rdata = (data_q & dir_q) | (sync_lvl & ~dir_q);
            ADDR_DIR:   bus_rdata = dir_q;
            ADDR_STY0:  bus_rdata = sty0_q;
            ADDR_STY1:  bus_rdata = sty1_q;
            ADDR_FSEL0: bus_rdata = fsel0_q;
            ADDR_FSEL1: bus_rdata = fsel1_q;
            default:    bus_rdata = '0;
        endcase
    end

    assign ext_irq = sync_lvl;
endmodule

// File: rtl/gpio_mux_port_chk.sv
`timescale 1ns/1ps
module gpio_mux_port_chk #(
    parameter int N      = 8,
    parameter int STAGES = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_we,
    input logic [2:0]   bus_addr,
    input logic [N-1:0] bus_wdata,
    input logic [N-1:0] pad_in,
    input logic [N-1:0] pad_oe,
    input logic [N-1:0] pad_out,
    input logic [N-1:0] pad_pu,
    input logic [N-1:0] pad_pd,
    input logic [N-1:0] ext_irq,
    input logic [N-1:0] dir_q,
    input logic [N-1:0] sty0_q,
    input logic [N-1:0] sty1_q,
    input logic [N-1:0] fsel0_q,
    input logic [N-1:0] fsel1_q
);
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_quiet_in_reset_R1: assert ((pad_oe | pad_pu | pad_pd) == '0);
        end
    end

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 3'd1) |=> (dir_q == $past(bus_wdata)));

    assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(dir_q) && $stable(sty0_q) && $stable(sty1_q)
                     && $stable(fsel0_q) && $stable(fsel1_q)));

    assert_off_style_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q & ~sty0_q & ~sty1_q & pad_oe) == '0);

    assert_high_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q & sty0_q & ~sty1_q & pad_oe & ~pad_out) == '0);

    assert_low_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q & ~sty0_q & sty1_q & pad_oe & pad_out) == '0);

    assert_input_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (~dir_q & pad_oe) == '0);

    assert_out_idle_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    assert_pull_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_pd) | ((pad_pu | pad_pd) & dir_q)) == '0);

    if (STAGES == 2) begin : g_lat
        logic [1:0] warm_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              warm_q <= '0;
            else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
        end
        assert_irq_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q >= 2'd2) |-> (ext_irq == $past(pad_in, 2)));
    end
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.N(N), .STAGES(SYNC_STAGES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd),
    .ext_irq   (ext_irq),
    .dir_q     (dir_q),
    .sty0_q    (sty0_q),
    .sty1_q    (sty1_q),
    .fsel0_q   (fsel0_q),
    .fsel1_q   (fsel1_q)
);

// File: tb/gpio_mux_port_test.sv
`timescale 1ns/1ps
module gpio_mux_port_test;
    localparam int N          = 8;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_STEPS = 3000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         bus_we;
    logic [2:0]   bus_addr;
    logic [N-1:0] bus_wdata, bus_rdata;
    logic [N-1:0] alt2_val, alt2_en, alt3_val, alt3_en, alt4_val, alt4_en;
    logic [N-1:0] pad_in, pad_oe, pad_out, pad_pu, pad_pd, ext_irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_mux_port uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alt2_val(alt2_val), .alt2_en(alt2_en), .alt3_val(alt3_val),
        .alt3_en(alt3_en), .alt4_val(alt4_val), .alt4_en(alt4_en),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .ext_irq(ext_irq)
    );

    // Behavioural reference state
    logic [N-1:0] m_reg [6];
    logic [N-1:0] m_sync [$];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < 6; r++) m_reg[r] = '0;
            m_reg[1] = '1;
            m_sync = '{'0, '0};
        end else begin
            if (bus_we && bus_addr < 3'd6) m_reg[bus_addr] = bus_wdata;
            m_sync.push_back(pad_in);
            void'(m_sync.pop_front());
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] exp_rdata(input logic [2:0] a);
        if (a == 3'd0) return (m_reg[0] & m_reg[1]) | (m_sync[0] & ~m_reg[1]);
        if (a < 3'd6)  return m_reg[a];
        return '0;
    endfunction

    task automatic compare_all();
        for (int i = 0; i < N; i++) begin
            int  sty, fs;
            bit  v, e, eoe, eout, epu, epd;
            string tag;
            sty = {m_reg[3][i], m_reg[2][i]};
            fs  = {m_reg[5][i], m_reg[4][i]};
            case (fs)
                1:       begin v = alt2_val[i]; e = alt2_en[i]; end
                2:       begin v = alt3_val[i]; e = alt3_en[i]; end
                3:       begin v = alt4_val[i]; e = alt4_en[i]; end
                default: begin v = m_reg[0][i]; e = 1'b1; end
            endcase
            eoe = 0; epu = 0; epd = 0;
            if (m_reg[1][i]) begin
                if (sty == 1)      eoe = e && v;
                else if (sty == 2) eoe = e && !v;
                else if (sty == 3) eoe = e;
                eout = eoe && v;
                if (fs != 0)       tag = "R10";
                else if (sty == 0) tag = "R3";
                else if (sty == 1) tag = "R4";
                else if (sty == 2) tag = "R5";
                else               tag = "R6";
            end else begin
                eout = 0;
                epd = (sty == 1);
                epu = (sty == 2);
                tag = "R7";
            end
            chk(tag, {pad_oe[i], pad_out[i], pad_pu[i], pad_pd[i]},
                {eoe, eout, epu, epd});
        end
        chk("R11", pad_out & ~pad_oe, '0);
        chk("R12", pad_pu & pad_pd, '0);
        chk("R9", ext_irq, m_sync[0]);
        chk(bus_addr == 3'd0 ? "R8" : "R2", bus_rdata, exp_rdata(bus_addr));
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_inputs();
        bus_we = 0; bus_addr = 0; bus_wdata = 0;
        alt2_val = 0; alt2_en = 0; alt3_val = 0; alt3_en = 0;
        alt4_val = 0; alt4_en = 0; pad_in = 0;
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [N-1:0] d);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_we = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog (all requirements): actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0;
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        bus_addr = 3'd1;
        #1 chk("R1", bus_rdata, 8'hFF);
        chk("R1", {pad_oe, pad_pu, pad_pd}, '0);
        bus_addr = 3'd2;
        #1 chk("R1", bus_rdata, 8'h00);
        @(negedge clk);
        rst_n = 1;
        bus_addr = 3'd0;
        step();
        chk("R1", {pad_oe, pad_pu, pad_pd}, '0);

        // R8: input latency
        write_reg(3'd1, 8'h00);
        pad_in = 8'hA5; bus_addr = 3'd0;
        step();
        chk("R8", bus_rdata, 8'h00);
        step();
        chk("R8", bus_rdata, 8'hA5);
        chk("R9", ext_irq, 8'hA5);

        // R7: pulls on input pins
        write_reg(3'd2, 8'h0F);
        write_reg(3'd3, 8'h33);
        step();
        chk("R7", pad_pd, 8'h0C);
        chk("R7", pad_pu, 8'h30);

        // R6 / R10: push-pull with data, then alternate
        write_reg(3'd1, 8'hFF);
        write_reg(3'd2, 8'hFF);
        write_reg(3'd3, 8'hFF);
        write_reg(3'd0, 8'h5A);
        step();
        chk("R6", pad_oe, 8'hFF);
        chk("R6", pad_out, 8'h5A);
        alt3_val = 8'hC3; alt3_en = 8'hF0;
        write_reg(3'd5, 8'hFF);
        step();
        chk("R10", pad_oe, 8'hF0);
        chk("R10", pad_out, 8'hC0);

        // R2: unused addresses
        write_reg(3'd6, 8'h77);
        bus_addr = 3'd6;
        step();
        chk("R2", bus_rdata, 8'h00);
        write_reg(3'd5, 8'h00);

        // Random phase, compared every cycle
        for (int n = 0; n < RAND_STEPS; n++) begin
            bus_we    = ($urandom_range(0, 2) == 0);
            bus_addr  = 3'($urandom_range(0, 7));
            bus_wdata = 8'($urandom);
            pad_in    = 8'($urandom);
            alt2_val  = 8'($urandom); alt2_en = 8'($urandom);
            alt3_val  = 8'($urandom); alt3_en = 8'($urandom);
            alt4_val  = 8'($urandom); alt4_en = 8'($urandom);
            step();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule